// File: doc/BRIEF.md
# Hashed Page Table Search Engine

This block turns a virtual page number into a real page number by walking a hashed translation table held in memory. When a translation cache misses, it hands the page number to the engine. The engine hashes the number, finds the matching 128-byte group of eight 16-byte entries, and reads entries one at a time through a 16-byte memory read port.

The walk covers the even slots of the primary group, then its odd slots. It then covers the secondary group in the same order. The secondary group is located by the bit-inverted hash. The first entry that qualifies ends the walk with a hit and its real page number. If all sixteen probes miss, the walk ends with a page fault.

The table base and the size mask come from configuration inputs. These inputs, and the page number, are captured when the request is accepted. A table must be at least 256 KB, which the mask expresses as its low bits set.

Top module: `hpt_walker`

## Requirements
- R1: The primary hash is `vpn[18:0] XOR vpn[37:19]`. A group address is `cfg_base`, with its low 7 bits cleared, ORed with `(hash AND cfg_mask) << 7`. The entry read at slot s sits at the group address plus `16*s`.
- R2: The secondary group uses the one's complement of the primary hash, ANDed with `cfg_mask`, and is placed the same way as in R1.
- R3: Probes follow a fixed order: primary slots 0,2,4,6, then primary 1,3,5,7, then secondary 0,2,4,6, then secondary 1,3,5,7.
- R4: Each entry is 128 bits. Bit 0 is valid, bit 1 is hash-select, bits [43:2] are the 42-bit tag, and bits [93:64] are the 30-bit real page number. An entry qualifies only if it is valid, its tag equals `vpn[52:11]`, and its hash-select bit equals 0 in the primary group and 1 in the secondary group.
- R5: The walk stops at the first qualifying entry. It then pulses `rsp_valid` with `rsp_hit=1`, `rsp_fault=0` and that entry's real page number, and issues no further reads.
- R6: When none of the sixteen probes qualifies, the engine pulses `rsp_valid` with `rsp_fault=1` and `rsp_hit=0`, after exactly sixteen reads.
- R7: Each probe issues exactly one single-cycle read. No read is issued while another is still outstanding.
- R8: `req_vpn`, `cfg_base` and `cfg_mask` are captured when a request is accepted. Later changes to them do not affect the walk in progress.
- R9: After reset, `req_ready=1` and `mem_req_valid=rsp_valid=0`. `req_ready` is low from acceptance until the cycle after the one-cycle `rsp_valid` pulse.
- R10: A `mem_rsp_valid` pulse while no read is outstanding is ignored: it issues no read and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Engine idle, request accepted when both are high |
| req_vpn | input | 53 | Virtual page number to translate |
| cfg_base | input | 42 | Table base real address |
| cfg_mask | input | 19 | Hash mask giving the table size |
| rsp_valid | output | 1 | One-cycle walk result strobe |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | Page fault, no entry qualified |
| rsp_rpn | output | 30 | Real page number of the hit |
| mem_req_valid | output | 1 | Read request strobe |
| mem_req_addr | output | 42 | 16-byte aligned read address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 128 | One table entry |

## Verification
The bench places decoy entries that each fail one condition: a valid entry with the right tag but the wrong hash-select bit, or a matching tag with the valid bit clear. A design that skipped any condition would stop early with the wrong page number.

Two qualifying entries sit in an even and an odd slot. This catches a design that scans slots linearly, because it would return the odd one.

A zero mask folds both groups onto the base address, so only hash-select tells them apart. A fully missing translation must take exactly sixteen reads before the fault; a design with an off-by-one in its counter would fault early or read past the end.

Configuration is scrambled in the middle of a walk, and stray read data is sent while the engine is idle. These checks expose a design that reads live inputs or responds to unsolicited data.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
    // Entry layout inside a 16-byte table entry
    localparam int ENTRY_W    = 128;
    localparam int E_VALID    = 0;
    localparam int E_HSEL     = 1;
    localparam int E_TAG_LSB  = 2;
    localparam int E_RPN_LSB  = 64;
    // Group and slot geometry
    localparam int SLOTS      = 8;
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int SLOT_SHIFT = 4;
    localparam int GRP_SHIFT  = SLOT_SHIFT + SLOT_W;
    localparam int PROBES     = 2 * SLOTS;
    localparam int PROBE_W    = $clog2(PROBES);

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_ISSUE = 2'd1,
        W_WAIT  = 2'd2,
        W_DONE  = 2'd3
    } walk_st_e;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
    import hpt_pkg::*;
#(
    parameter int VPN_W  = 53,
    parameter int HASH_W = 19,
    parameter int RA_W   = 42
) (
    input  logic [VPN_W-1:0]  vpn,
    input  logic [RA_W-1:0]   base,
    input  logic [HASH_W-1:0] mask,
    output logic [RA_W-1:0]   prim_grp,
    output logic [RA_W-1:0]   sec_grp
);
    localparam logic [RA_W-1:0] LOW_MASK = (RA_W'(1) << GRP_SHIFT) - RA_W'(1);

    logic [HASH_W-1:0] hash;
    logic [HASH_W-1:0] prim_idx;
    logic [HASH_W-1:0] sec_idx;
    logic [RA_W-1:0]   base_al;

    always_comb begin
        hash     = vpn[HASH_W-1:0] ^ vpn[2*HASH_W-1:HASH_W];
        prim_idx = hash & mask;
        sec_idx  = (~hash) & mask;
        base_al  = base & ~LOW_MASK;
        prim_grp = base_al | (RA_W'(prim_idx) << GRP_SHIFT);
        sec_grp  = base_al | (RA_W'(sec_idx) << GRP_SHIFT);
    end
endmodule

// File: rtl/hpt_probe_order.sv
module hpt_probe_order
    import hpt_pkg::*;
(
    input  logic [PROBE_W-1:0] probe,
    output logic [SLOT_W-1:0]  slot,
    output logic               second
);
    // Within a group: four even slots first, then the four odd ones.
    always_comb begin
        slot   = {probe[SLOT_W-2:0], probe[SLOT_W-1]};
        second = probe[PROBE_W-1];
    end
endmodule

// File: rtl/hpt_entry_match.sv
module hpt_entry_match
    import hpt_pkg::*;
#(
    parameter int TAG_W = 42,
    parameter int RPN_W = 30
) (
    input  logic [ENTRY_W-1:0] entry,
    input  logic [TAG_W-1:0]   tag,
    input  logic               second,
    output logic               hit,
    output logic [RPN_W-1:0]   rpn
);
    logic             v;
    logic             hsel;
    logic [TAG_W-1:0] etag;

    always_comb begin
        v    = entry[E_VALID];
        hsel = entry[E_HSEL];
        etag = entry[E_TAG_LSB +: TAG_W];
        rpn  = entry[E_RPN_LSB +: RPN_W];
        hit  = v && (etag == tag) && (hsel == second);
    end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int VPN_W    = 53,
    parameter int HASH_W   = 19,
    parameter int RA_W     = 42,
    parameter int RPN_W    = 30,
    parameter int TAG_DROP = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [VPN_W-1:0]    req_vpn,
    input  logic [RA_W-1:0]     cfg_base,
    input  logic [HASH_W-1:0]   cfg_mask,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic                rsp_fault,
    output logic [RPN_W-1:0]    rsp_rpn,
    output logic                mem_req_valid,
    output logic [RA_W-1:0]     mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [ENTRY_W-1:0]  mem_rsp_data
);
    localparam int TAG_W = VPN_W - TAG_DROP;

    typedef struct packed {
        walk_st_e             st;
        logic [PROBE_W-1:0]   probe;
        logic [TAG_W-1:0]     tag;
        logic [RA_W-1:0]      pgrp;
        logic [RA_W-1:0]      sgrp;
        logic                 hit;
        logic [RPN_W-1:0]     rpn;
    } walk_t;

    walk_t w_d, w_q;

    logic [RA_W-1:0]   new_pgrp, new_sgrp;
    logic [SLOT_W-1:0] slot;
    logic              second;
    logic              ent_hit;
    logic [RPN_W-1:0]  ent_rpn;

    hpt_hash #(.VPN_W(VPN_W), .HASH_W(HASH_W), .RA_W(RA_W)) u_hash (
        .vpn      (req_vpn),
        .base     (cfg_base),
        .mask     (cfg_mask),
        .prim_grp (new_pgrp),
        .sec_grp  (new_sgrp)
    );

    hpt_probe_order u_order (
        .probe  (w_q.probe),
        .slot   (slot),
        .second (second)
    );

    hpt_entry_match #(.TAG_W(TAG_W), .RPN_W(RPN_W)) u_match (
        .entry  (mem_rsp_data),
        .tag    (w_q.tag),
        .second (second),
        .hit    (ent_hit),
        .rpn    (ent_rpn)
    );

    always_comb begin
        w_d = w_q;
        unique case (w_q.st)
            W_IDLE: begin
                if (req_valid) begin
                    w_d.st    = W_ISSUE;
                    w_d.probe = '0;
                    w_d.tag   = req_vpn[VPN_W-1:TAG_DROP];
                    w_d.pgrp  = new_pgrp;
                    w_d.sgrp  = new_sgrp;
                    w_d.hit   = 1'b0;
                    w_d.rpn   = '0;
                end
            end
            W_ISSUE: w_d.st = W_WAIT;
            W_WAIT: begin
                if (mem_rsp_valid) begin
                    if (ent_hit) begin
                        w_d.st  = W_DONE;
                        w_d.hit = 1'b1;
                        w_d.rpn = ent_rpn;
                    end else if (&w_q.probe) begin
                        w_d.st  = W_DONE;
                        w_d.hit = 1'b0;
                    end else begin
                        w_d.st    = W_ISSUE;
                        w_d.probe = w_q.probe + PROBE_W'(1);
                    end
                end
            end
            W_DONE: w_d.st = W_IDLE;
            default: w_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '{st: W_IDLE, probe: '0, tag: '0, pgrp: '0, sgrp: '0,
                     hit: 1'b0, rpn: '0};
        end else begin
            w_q <= w_d;
        end
    end

    always_comb begin
        req_ready     = (w_q.st == W_IDLE);
        mem_req_valid = (w_q.st == W_ISSUE);
        mem_req_addr  = (second ? w_q.sgrp : w_q.pgrp)
                      | (RA_W'(slot) << SLOT_SHIFT);
        rsp_valid     = (w_q.st == W_DONE);
        rsp_hit       = rsp_valid && w_q.hit;
        rsp_fault     = rsp_valid && !w_q.hit;
        rsp_rpn       = w_q.rpn;
    end
endmodule

module hpt_walker_chk #(
    parameter int RA_W = 42
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_fault,
    input logic            mem_req_valid,
    input logic [RA_W-1:0] mem_req_addr,
    input logic            mem_rsp_valid
);
    logic [4:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (req_valid && req_ready) cnt <= '0;
        else if (mem_req_valid)          cnt <= cnt + 5'd1;
    end

    a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[3:0] == 4'd0));
    a_r5_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit ^ rsp_fault));
    a_r6_fault_after_all: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (cnt == 5'd16));
    a_r7_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
    a_r7_probe_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= 5'd16);
    a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));
    a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || rsp_valid) |-> !req_ready);
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && mem_rsp_valid) |=> !rsp_valid);
endmodule

bind hpt_walker hpt_walker_chk #(.RA_W(RA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid)
);

// File: tb/tb_hpt_walker.sv
`timescale 1ns/1ps
module tb_hpt_walker;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [52:0]   req_vpn = '0;
    logic [41:0]   cfg_base = '0;
    logic [18:0]   cfg_mask = '0;
    logic          rsp_valid, rsp_hit, rsp_fault;
    logic [29:0]   rsp_rpn;
    logic          mem_req_valid;
    logic [41:0]   mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [127:0]  mem_rsp_data = '0;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    hpt_walker dut (.*);

    // planted memory entries
    logic [41:0]  pl_addr [8];
    logic [127:0] pl_data [8];
    int           pl_n;
    logic [41:0]  exp_addr [16];

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] make_entry(input bit v, input bit h,
                                                input logic [41:0] tag,
                                                input logic [29:0] rpn);
        logic [127:0] d = '0;
        d[0] = v; d[1] = h; d[43:2] = tag; d[93:64] = rpn;
        return d;
    endfunction

    function automatic logic [41:0] probe_addr(input logic [52:0] vpn,
                                               input logic [41:0] base,
                                               input logic [18:0] mask,
                                               input int p);
        logic [18:0] h = vpn[18:0] ^ vpn[37:19];
        logic [18:0] idx = (p >= 8) ? (~h & mask) : (h & mask);
        int s = ((p % 4) * 2) + ((p % 8) / 4);
        return ({base[41:7], 7'd0} | ({23'd0, idx} << 7)) + 42'(s * 16);
    endfunction

    function automatic logic [127:0] mem_model(input logic [41:0] a);
        for (int i = 0; i < pl_n; i++) if (pl_addr[i] == a) return pl_data[i];
        return make_entry(a[4] ^ a[9], a[5], a ^ 42'h155_5555_5555, a[29:0]);
    endfunction

    task automatic plant(input logic [41:0] a, input logic [127:0] d);
        pl_addr[pl_n] = a; pl_data[pl_n] = d; pl_n++;
    endtask

    task automatic run_walk(input logic [52:0] vpn, input logic [41:0] base,
                            input logic [18:0] mask, input bit scramble,
                            input string req);
        bit exp_hit = 0; logic [29:0] exp_rpn = '0; int exp_n = 16;
        int n = 0; int guard = 0; bit seq_ok = 1; bit done = 0;
        logic [41:0] a;
        for (int p = 0; p < 16; p++) begin
            logic [127:0] d;
            exp_addr[p] = probe_addr(vpn, base, mask, p);
            d = mem_model(exp_addr[p]);
            if (!exp_hit && d[0] && d[43:2] == vpn[52:11] && d[1] == (p >= 8)) begin
                exp_hit = 1; exp_rpn = d[93:64]; exp_n = p + 1;
            end
        end
        @(negedge clk);
        req_valid = 1; req_vpn = vpn; cfg_base = base; cfg_mask = mask;
        @(negedge clk);
        req_valid = 0;
        if (scramble) begin
            req_vpn = ~vpn; cfg_base = ~base; cfg_mask = ~mask;
        end
        while (!done && guard < 400) begin
            guard++;
            if (rsp_valid) done = 1;
            else if (mem_req_valid) begin
                a = mem_req_addr;
                if (n >= 16 || a !== exp_addr[n]) seq_ok = 0;
                n++;
                repeat (1 + $urandom % 3) @(negedge clk);
                mem_rsp_valid = 1; mem_rsp_data = mem_model(a);
                @(negedge clk);
                mem_rsp_valid = 0; mem_rsp_data = $urandom;
            end else @(negedge clk);
        end
        check(done, {req, " R9 walk ends"}, 64'(done), 1);
        check(seq_ok && n == exp_n, {req, " R3 R7 probe sequence"}, 64'(n), 64'(exp_n));
        check(rsp_hit == exp_hit && rsp_fault == !exp_hit, {req, " R5 R6 outcome"},
              64'(rsp_hit), 64'(exp_hit));
        if (exp_hit) check(rsp_rpn == exp_rpn, {req, " R5 rpn"}, 64'(rsp_rpn), 64'(exp_rpn));
        @(negedge clk);
        check(req_ready && !rsp_valid, {req, " R9 idle after pulse"}, 64'(req_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [52:0] v;
        logic [41:0] b;
        logic [18:0] m;
        void'($urandom(32'd7331));
        pl_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(req_ready && !mem_req_valid && !rsp_valid, "R9 reset state",
              {61'd0, req_ready, mem_req_valid, rsp_valid}, 64'h4);

        v = 53'h0_1234_5678_9ABC; b = 42'h100_0000_0000; m = 19'h00FFF;
        // R1: hit in primary slot 0
        pl_n = 0; plant(probe_addr(v, b, m, 0), make_entry(1, 0, v[52:11], 30'h1111));
        run_walk(v, b, m, 0, "R1 primary slot0");
        // R3: hit at probe 7 (slot 7)
        pl_n = 0; plant(probe_addr(v, b, m, 7), make_entry(1, 0, v[52:11], 30'h2222));
        run_walk(v, b, m, 0, "R3 primary slot7");
        // R3: odd slot 1 and even slot 2 both qualify -> slot 2 first
        pl_n = 0;
        plant(probe_addr(v, b, m, 4), make_entry(1, 0, v[52:11], 30'h3331));
        plant(probe_addr(v, b, m, 1), make_entry(1, 0, v[52:11], 30'h3332));
        run_walk(v, b, m, 0, "R3 even before odd");
        // R4: invalid and wrong hash-select decoys; R2 secondary hit
        pl_n = 0;
        plant(probe_addr(v, b, m, 0), make_entry(0, 0, v[52:11], 30'h4441));
        plant(probe_addr(v, b, m, 2), make_entry(1, 1, v[52:11], 30'h4442));
        plant(probe_addr(v, b, m, 8), make_entry(1, 0, v[52:11], 30'h4443));
        plant(probe_addr(v, b, m, 10), make_entry(1, 1, v[52:11], 30'h4444));
        run_walk(v, b, m, 0, "R2 R4 decoys secondary");
        // R6: nothing planted
        pl_n = 0;
        run_walk(v, b, m, 0, "R6 fault");
        // R8: scramble inputs mid-walk
        pl_n = 0; plant(probe_addr(v, b, m, 13), make_entry(1, 1, v[52:11], 30'h5555));
        run_walk(v, b, m, 1, "R8 capture");
        // R2: zero mask folds groups; only hash-select separates them
        pl_n = 0; plant(probe_addr(v, b, 19'd0, 0), make_entry(1, 1, v[52:11], 30'h6666));
        run_walk(v, b, 19'd0, 0, "R2 zero mask");
        // R10: stray data while idle
        @(negedge clk);
        mem_rsp_valid = 1; mem_rsp_data = make_entry(1, 0, v[52:11], 30'h7777);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!rsp_valid && !mem_req_valid && req_ready, "R10 stray data ignored",
                  {62'd0, rsp_valid, mem_req_valid}, 0);
        end
        mem_rsp_valid = 0;
        // random walks
        for (int t = 0; t < 40; t++) begin
            int p;
            v = {$urandom, $urandom};
            b = {$urandom, $urandom};
            m = 19'((1 << (4 + $urandom % 9)) - 1);
            p = $urandom % 17;
            pl_n = 0;
            if (p < 16) begin
                if (p > 0) plant(probe_addr(v, b, m, $urandom % p),
                                 make_entry(1, (p < 8), v[52:11], 30'h3FF));
                plant(probe_addr(v, b, m, p), make_entry(1, (p >= 8), v[52:11], 30'($urandom)));
            end
            run_walk(v, b, m, t[0], "R1 R3 random");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule